// File: doc/BRIEF.md
# Exception Entry and Vector Selection Unit

This unit is the entry stage of a system coprocessor for a MIPS-like core. When the pipeline raises an exception it presents a cause code, the current program counter and a flag that says whether the faulting instruction sits in a branch delay slot. In the cycle it sees the request, the unit works out the exception class and the handler address. On the next clock edge it commits the new Cause, EPC and Status values and pulses a redirect strobe that carries the handler address.

The handler address is a base plus an offset. The offset depends on two things: whether the core is at error level 2 (Status ERL set) and which class the code decodes to. An exception that arrives while the core is already in exception state (Status EXL set) always goes to the general offset and keeps the saved EPC. One Status bit picks a boot base or a normal base: BEV at levels 0 and 1, DEV at level 2.

The unit also gates two pending interrupt lines, one from the interrupt controller and one from the DMA controller. An interrupt becomes an exception only when the global enables and the source's own master bit allow it. The execution stage writes Status through a plain write port.

Top module: `trap_entry`

## Requirements
- R1: After reset, status_o is 0x70400004, prid_o is 0x00002E20, config_o is 0x00000440, redirect_pc_o is 0xBFC00000, and redirect_o, cause_o, epc_o and l2_err_o are 0.
- R2: With ERL (Status bit 2) at 0, the offset is chosen from code & 0x7C: 0x000 when it lies from 0x08 to 0x0C (refill), 0x200 when it is 0 (interrupt), and 0x180 otherwise.
- R3: The base is 0x80000000 when the selecting bit is 0 and 0xBFC00200 when it is 1. The selecting bit is BEV (Status bit 22) when ERL is 0 and DEV (Status bit 23) when ERL is 1. redirect_pc_o is base plus offset.
- R4: With ERL at 1 and code bits [17:15] at 0 or 1 (reset/NMI class), redirect_pc_o becomes 0xBFC00000 and Cause, EPC, Status and l2_err_o keep their values.
- R5: With ERL at 1, code bits [17:15] equal to 2 (performance counter) give offset 0x080, and equal to 3 (debug) give offset 0x100.
- R6: With ERL at 1, code bits [17:15] of 4 to 7 give offset 0x180 and set l2_err_o. l2_err_o then stays set until reset.
- R7: Every exception that is not of the reset class writes code bits [15:0] into cause_o[15:0] and clears cause_o[30:16].
- R8: When EXL (Status bit 1) is 0, an exception that is not of the reset class sets EXL. It loads epc_o with pc_i−4 and sets cause_o[31] if bd_i is 1; otherwise it loads pc_i and clears cause_o[31].
- R9: When EXL is 1, an exception leaves epc_o and cause_o[31] unchanged and forces the offset to 0x180.
- R10: An interrupt starts an exception only if IE (bit 0) and EIE (bit 16) are 1, EXL and ERL are 0, and either irq_ctl_i is set with Status bit 10 at 1 or irq_dma_i is set with Status bit 11 at 1. Its code has bit 10 equal to irq_ctl_i, bit 11 equal to irq_dma_i and all other bits 0. It uses pc_i and bd_i.
- R11: redirect_o is high for one clock in the cycle after each cycle in which an exception is taken, and low otherwise.
- R12: An explicit request takes precedence over an interrupt in the same cycle. A Status write (st_we_i) in a cycle where an exception is taken is discarded; otherwise status_o takes st_wd_i on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Exception request |
| code_i | input | 18 | Exception cause code |
| bd_i | input | 1 | Current instruction is in a branch delay slot |
| pc_i | input | 32 | Current instruction address |
| irq_ctl_i | input | 1 | Interrupt controller pending |
| irq_dma_i | input | 1 | DMA controller pending |
| st_we_i | input | 1 | Status write enable |
| st_wd_i | input | 32 | Status write data |
| redirect_o | output | 1 | One-clock redirect strobe |
| redirect_pc_o | output | 32 | Handler / restart address |
| status_o | output | 32 | Status register |
| cause_o | output | 32 | Cause register |
| epc_o | output | 32 | Exception PC |
| prid_o | output | 32 | Processor identification constant |
| config_o | output | 32 | Configuration constant |
| l2_err_o | output | 1 | Sticky undefined level-2 class flag |

## Verification
Two functions can fall in one cycle: an explicit request and an enabled interrupt, or an exception and a Status write. The bench provokes both. It raises a request together with a pending, enabled interrupt, and it issues a Status write in the same cycle as a request, both in directed steps and in a long pseudo-random phase. A behavioural model applies the precedence rules: the request wins, and the write is dropped. After every edge the model's redirect target, Cause, EPC and Status are compared with the ports, so a lost precedence or an applied write shows up at once.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int XW = 32;
  localparam int CW = 18;
  localparam int OFS_W = 12;

  // Status bit positions
  localparam int ST_IE  = 0;
  localparam int ST_EXL = 1;
  localparam int ST_ERL = 2;
  localparam int ST_ICM = 10;
  localparam int ST_DCM = 11;
  localparam int ST_EIE = 16;
  localparam int ST_BEV = 22;
  localparam int ST_DEV = 23;

  // interrupt code bit positions
  localparam int IC_CTL = 10;
  localparam int IC_DMA = 11;

  typedef enum logic [2:0] {
    VC_REFILL, VC_INTR, VC_GENERAL, VC_PERF, VC_DEBUG, VC_RESET, VC_UNDEF
  } vec_cls_e;
endpackage

// File: rtl/trap_classify.sv
module trap_classify
  import trap_pkg::*;
(
  input  logic [4:0]       exc_fld,   // code bits [6:2]
  input  logic [2:0]       lvl_fld,   // code bits [17:15]
  input  logic             erl,
  input  logic             exl,
  output vec_cls_e         cls,
  output logic [OFS_W-1:0] offset,
  output logic             undef_l2
);
  logic [6:0] masked;
  assign masked = {exc_fld, 2'b00};

  always_comb begin
    cls = VC_GENERAL;
    if (erl) begin
      case (lvl_fld)
        3'd0, 3'd1: cls = VC_RESET;
        3'd2:       cls = VC_PERF;
        3'd3:       cls = VC_DEBUG;
        default:    cls = VC_UNDEF;
      endcase
    end else if (masked >= 7'h08 && masked <= 7'h0C) begin
      cls = VC_REFILL;
    end else if (masked == 7'h00) begin
      cls = VC_INTR;
    end
  end

  always_comb begin
    case (cls)
      VC_REFILL: offset = 12'h000;
      VC_INTR:   offset = 12'h200;
      VC_PERF:   offset = 12'h080;
      VC_DEBUG:  offset = 12'h100;
      default:   offset = 12'h180;
    endcase
    if (exl && cls != VC_RESET) offset = 12'h180;
  end

  assign undef_l2 = (cls == VC_UNDEF);
endmodule

// File: rtl/trap_irq_gate.sv
module trap_irq_gate
  import trap_pkg::*;
(
  input  logic          ie,
  input  logic          eie,
  input  logic          exl,
  input  logic          erl,
  input  logic          m_ctl,
  input  logic          m_dma,
  input  logic          p_ctl,
  input  logic          p_dma,
  output logic          take,
  output logic [CW-1:0] code
);
  logic src_ok;
  assign src_ok = (p_ctl & m_ctl) | (p_dma & m_dma);
  assign take   = src_ok & ie & eie & ~exl & ~erl;

  always_comb begin
    code         = '0;
    code[IC_CTL] = p_ctl;
    code[IC_DMA] = p_dma;
  end
endmodule

// File: rtl/trap_entry.sv
module trap_entry
  import trap_pkg::*;
#(
  parameter logic [XW-1:0] RST_STATUS = 32'h7040_0004,
  parameter logic [XW-1:0] RST_PRID   = 32'h0000_2E20,
  parameter logic [XW-1:0] RST_CONFIG = 32'h0000_0440,
  parameter logic [XW-1:0] RESET_PC   = 32'hBFC0_0000,
  parameter logic [XW-1:0] BOOT_BASE  = 32'hBFC0_0200,
  parameter logic [XW-1:0] NORM_BASE  = 32'h8000_0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_i,
  input  logic [CW-1:0] code_i,
  input  logic          bd_i,
  input  logic [XW-1:0] pc_i,
  input  logic          irq_ctl_i,
  input  logic          irq_dma_i,
  input  logic          st_we_i,
  input  logic [XW-1:0] st_wd_i,
  output logic          redirect_o,
  output logic [XW-1:0] redirect_pc_o,
  output logic [XW-1:0] status_o,
  output logic [XW-1:0] cause_o,
  output logic [XW-1:0] epc_o,
  output logic [XW-1:0] prid_o,
  output logic [XW-1:0] config_o,
  output logic          l2_err_o
);
  logic [XW-1:0]    status_q, cause_q, epc_q, pc_q;
  logic             redir_q, err_q;
  logic             irq_take, exc_any;
  logic [CW-1:0]    irq_code, exc_code;
  vec_cls_e         cls;
  logic [OFS_W-1:0] offset;
  logic             undef_l2, base_sel;
  logic [XW-1:0]    target;

  trap_irq_gate u_gate (
    .ie    (status_q[ST_IE]),
    .eie   (status_q[ST_EIE]),
    .exl   (status_q[ST_EXL]),
    .erl   (status_q[ST_ERL]),
    .m_ctl (status_q[ST_ICM]),
    .m_dma (status_q[ST_DCM]),
    .p_ctl (irq_ctl_i),
    .p_dma (irq_dma_i),
    .take  (irq_take),
    .code  (irq_code)
  );

  // explicit request has precedence
  assign exc_any  = req_i | irq_take;
  assign exc_code = req_i ? code_i : irq_code;

  trap_classify u_cls (
    .exc_fld  (exc_code[6:2]),
    .lvl_fld  (exc_code[17:15]),
    .erl      (status_q[ST_ERL]),
    .exl      (status_q[ST_EXL]),
    .cls      (cls),
    .offset   (offset),
    .undef_l2 (undef_l2)
  );

  assign base_sel = status_q[ST_ERL] ? status_q[ST_DEV] : status_q[ST_BEV];
  assign target   = (base_sel ? BOOT_BASE : NORM_BASE) + {{(XW-OFS_W){1'b0}}, offset};

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= RST_STATUS;
      cause_q  <= '0;
      epc_q    <= '0;
      pc_q     <= RESET_PC;
      redir_q  <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      redir_q <= exc_any;
      if (exc_any) begin
        if (cls == VC_RESET) begin
          pc_q <= RESET_PC;
        end else begin
          pc_q <= target;
          cause_q[30:16] <= '0;
          cause_q[15:0]  <= exc_code[15:0];
          if (!status_q[ST_EXL]) begin
            status_q[ST_EXL] <= 1'b1;
            cause_q[31]      <= bd_i;
            epc_q            <= bd_i ? pc_i - 32'd4 : pc_i;
          end
          if (undef_l2) err_q <= 1'b1;
        end
      end else if (st_we_i) begin
        status_q <= st_wd_i;
      end
    end
  end

  assign redirect_o    = redir_q;
  assign redirect_pc_o = pc_q;
  assign status_o      = status_q;
  assign cause_o       = cause_q;
  assign epc_o         = epc_q;
  assign prid_o        = RST_PRID;
  assign config_o      = RST_CONFIG;
  assign l2_err_o      = err_q;

  // ---- assertions ----
  assert_idle_no_redirect_R11: assert property (@(posedge clk) disable iff (rst)
    (!req_i && !irq_ctl_i && !irq_dma_i) |=> !redirect_o);

  assert_irq_blocked_R10: assert property (@(posedge clk) disable iff (rst)
    (!req_i && (!status_o[ST_IE] || !status_o[ST_EIE] || status_o[ST_EXL] || status_o[ST_ERL]))
    |=> !redirect_o);

  assert_exl_set_R8: assert property (@(posedge clk) disable iff (rst)
    (req_i && !status_o[ST_EXL] && cls != VC_RESET) |=> status_o[ST_EXL]);

  assert_epc_kept_R9: assert property (@(posedge clk) disable iff (rst)
    (req_i && status_o[ST_EXL]) |=> $stable(epc_o));

  assert_reset_class_R4: assert property (@(posedge clk) disable iff (rst)
    (req_i && cls == VC_RESET) |=> (redirect_pc_o == RESET_PC && $stable(status_o) && $stable(cause_o)));

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    l2_err_o |=> l2_err_o);
endmodule

// File: tb/test_trap_entry.sv
`timescale 1ns/1ps
module test_trap_entry;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic [17:0] code = '0;
  logic        bd = 1'b0;
  logic [31:0] pc = '0;
  logic        ictl = 1'b0, idma = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wd = '0;
  logic        redirect, l2err;
  logic [31:0] rpc, status, cause, epc, prid, config_v;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  logic [31:0] m_st, m_cause, m_epc, m_pc;
  logic        m_redir, m_err;
  string       pc_tag, st_tag;

  always #4 clk = ~clk;

  trap_entry i_trap_entry (
    .clk(clk), .rst(rst), .req_i(req), .code_i(code), .bd_i(bd), .pc_i(pc),
    .irq_ctl_i(ictl), .irq_dma_i(idma), .st_we_i(we), .st_wd_i(wd),
    .redirect_o(redirect), .redirect_pc_o(rpc), .status_o(status),
    .cause_o(cause), .epc_o(epc), .prid_o(prid), .config_o(config_v),
    .l2_err_o(l2err)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_st = 32'h7040_0004; m_cause = 0; m_epc = 0; m_pc = 32'hBFC0_0000;
    m_redir = 0; m_err = 0; pc_tag = "R1"; st_tag = "R1";
  endtask

  task automatic model_step();
    logic        irq;
    logic [31:0] c, off, base;
    int          lvl, f;
    logic        nbd;
    irq = ((m_st[10] & ictl) | (m_st[11] & idma)) & m_st[16] & m_st[0] & ~m_st[1] & ~m_st[2];
    m_redir = req | irq;
    st_tag = (m_redir && we) ? "R12" : "R8";
    if (!m_redir) begin
      if (we) m_st = wd;
      pc_tag = "R11";
      return;
    end
    if (req) c = {14'd0, code};
    else c = (32'(ictl) << 10) | (32'(idma) << 11);
    pc_tag = req ? ((irq) ? "R12" : "R2") : "R10";
    if (m_st[2]) begin
      lvl = int'(c[17:15]);
      if (lvl <= 1) begin
        m_pc = 32'hBFC0_0000; pc_tag = "R4";
        return;
      end
      if (lvl == 2) begin off = 32'h80; pc_tag = "R5"; end
      else if (lvl == 3) begin off = 32'h100; pc_tag = "R5"; end
      else begin off = 32'h180; m_err = 1; pc_tag = "R6"; end
      base = m_st[23] ? 32'hBFC0_0200 : 32'h8000_0000;
    end else begin
      f = int'(c & 32'h7C);
      if (f >= 8 && f <= 12) off = 0;
      else if (f == 0) off = 32'h200;
      else off = 32'h180;
      base = m_st[22] ? 32'hBFC0_0200 : 32'h8000_0000;
    end
    if (m_st[1]) begin
      off = 32'h180; nbd = m_cause[31]; pc_tag = "R9";
    end else begin
      nbd = bd; m_epc = bd ? pc - 4 : pc; m_st[1] = 1'b1;
    end
    m_cause = {nbd, 15'd0, c[15:0]};
    m_pc = base + off;
  endtask

  task automatic compare_all();
    check("R11", "redirect", {31'd0, redirect}, {31'd0, m_redir});
    check(pc_tag, "redirect_pc", rpc, m_pc);
    check("R7", "cause", cause, m_cause);
    check("R8", "epc", epc, m_epc);
    check(st_tag, "status", status, m_st);
    check("R6", "l2_err", {31'd0, l2err}, {31'd0, m_err});
  endtask

  // one cycle: inputs set at negedge, model updated at edge, compare at next negedge
  task automatic cyc(input logic r, input logic [17:0] cd, input logic b, input logic [31:0] p,
                     input logic ic, input logic id, input logic w, input logic [31:0] d);
    req = r; code = cd; bd = b; pc = p; ictl = ic; idma = id; we = w; wd = d;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic wst(input logic [31:0] d);
    cyc(0, 0, 0, 0, 0, 0, 1, d);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1", "status", status, 32'h7040_0004);
    check("R1", "prid", prid, 32'h0000_2E20);
    check("R1", "config", config_v, 32'h0000_0440);
    check("R1", "redirect_pc", rpc, 32'hBFC0_0000);
    check("R1", "redirect", {31'd0, redirect}, 32'd0);
    check("R1", "cause", cause, 0);
    check("R1", "epc", epc, 0);
    check("R1", "l2_err", {31'd0, l2err}, 0);

    // level 2 classes (ERL=1 after reset, DEV=0)
    cyc(1, 18'h10000, 0, 32'h1000, 0, 0, 0, 0);          // R5 perf
    check("R5", "perf target", rpc, 32'h8000_0080);
    cyc(1, 18'h08000, 1, 32'h2000, 0, 0, 0, 0);          // R4 reset class
    check("R4", "reset class target", rpc, 32'hBFC0_0000);
    cyc(1, 18'h18000, 0, 32'h3000, 0, 0, 0, 0);          // R9 EXL set forces 0x180
    check("R9", "forced target", rpc, 32'h8000_0180);
    check("R9", "epc kept", epc, 32'h1000);
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    check("R11", "single pulse", {31'd0, redirect}, 0);

    // level 0-1 with BEV=1 -> boot base (R3), refill (R2)
    wst(32'h0040_0000);
    cyc(1, 18'h00008, 0, 32'h4000, 0, 0, 0, 0);
    check("R3", "boot base refill", rpc, 32'hBFC0_0200);
    wst(32'h0);
    cyc(1, 18'h0000C, 1, 32'h5000, 0, 0, 0, 0);
    check("R8", "bd epc", epc, 32'h4FFC);
    check("R7", "cause bd", cause, 32'h8000_000C);
    wst(32'h0);
    cyc(1, 18'h00024, 0, 32'h5100, 0, 0, 0, 0);
    check("R2", "general", rpc, 32'h8000_0180);

    // interrupts (R10)
    wst(32'h0001_0C01);
    cyc(0, 0, 0, 32'h6000, 1, 0, 0, 0);
    check("R10", "irq target", rpc, 32'h8000_0200);
    check("R10", "irq cause", cause, 32'h0000_0400);
    cyc(0, 0, 0, 32'h6100, 0, 1, 0, 0);
    check("R10", "blocked by EXL", {31'd0, redirect}, 0);
    wst(32'h0001_0401);
    cyc(0, 0, 0, 32'h6200, 0, 1, 0, 0);
    check("R10", "dma master off", {31'd0, redirect}, 0);
    // R12 request beats interrupt, and write dropped
    wst(32'h0001_0C01);
    cyc(1, 18'h00010, 0, 32'h7000, 1, 1, 1, 32'h0000_0000);
    check("R12", "request wins", cause, 32'h0000_0010);
    check("R12", "write dropped", status, 32'h0001_0C03);

    // undefined level 2 class, DEV=1 (R6)
    wst(32'h0080_0004);
    cyc(1, 18'h20000, 0, 32'h8000, 0, 0, 0, 0);
    check("R6", "undef target", rpc, 32'hBFC0_0380);
    check("R6", "err set", {31'd0, l2err}, 1);
    wst(32'h0);
    cyc(1, 18'h0, 0, 32'h8100, 0, 0, 0, 0);
    check("R6", "err sticky", {31'd0, l2err}, 1);

    // pseudo-random phase
    for (int i = 0; i < 2000; i++) begin
      logic [17:0] cs;
      logic [31:0] sw;
      case ($urandom_range(0, 9))
        0: cs = 18'h00000; 1: cs = 18'h00008; 2: cs = 18'h0000C;
        3: cs = 18'h00400; 4: cs = 18'h08000; 5: cs = 18'h10000;
        6: cs = 18'h18000; 7: cs = 18'h28000; 8: cs = 18'h00004;
        default: cs = 18'($urandom);
      endcase
      sw = $urandom & 32'h00C1_0C07;
      if ($urandom_range(0, 3) == 0) sw[2] = 1'b0;
      cyc($urandom_range(0, 3) == 0, cs, 1'($urandom), {$urandom, 2'b00} & 32'hFFFF_FFFC,
          1'($urandom), 1'($urandom), $urandom_range(0, 2) == 0, sw);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule